// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order word address of a four-beat memory burst. When a burst begins, the two least significant bits of the externally presented address are captured as the starting point. Each cycle in which the advance input is high moves the burst to its next word; while advance is low the current word address is held, so the controller can insert wait states.

Two orderings are available through a static mode input. With mode low the sequence counts upward and wraps within the four-word block. With mode high the sequence is the starting value XOR a beat count that runs 0, 1, 2, 3. Only the low bits are produced here. The upper address bits never see a carry out of this block, so every burst stays inside its aligned four-word block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release with no load, `addr_o` is 00.
- R2: A cycle with `load_i` high makes `addr_o` equal to that cycle's `start_i` from the next cycle on, and restarts the beat count at 0.
- R3: When `load_i` and `adv_i` are high in the same cycle, the load wins and `addr_o` shows `start_i` with no step applied.
- R4: A cycle with `load_i` and `adv_i` both low leaves `addr_o` unchanged in the next cycle (burst suspended).
- R5: With `mode_i` = 0 (linear), each advance changes `addr_o` to its previous value plus one, modulo 4 (11 steps to 00).
- R6: With `mode_i` = 1 (interleaved), after k advances since the load `addr_o` equals the start XOR k. The sequences are 00,01,10,11 from 00; 01,00,11,10 from 01; 10,11,00,01 from 10; 11,10,01,00 from 11.
- R7: In either mode, four advances after a load bring `addr_o` back to the loaded start value. The internal beat count wraps from 3 to 0.
- R8: A load in the middle of a burst abandons it. The new start appears on the next cycle and the sequence continues from beat 0 of the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Starts a burst from `start_i` (either address strobe active) |
| adv_i | input | 1 | Steps the burst by one beat |
| mode_i | input | 1 | Static ordering select: 0 linear, 1 interleaved |
| start_i | input | 2 | Low bits of the external address at burst start |
| addr_o | output | 2 | Current low word address of the burst |

## Verification
A corrupted captured start or beat count is visible on `addr_o` in the very next cycle, because the output is a pure function of those two registers and the mode. A beat count that fails to wrap or steps during a suspend shows up as a wrong word within one to four beats. It also shows as a burst that does not return to its start after four advances. Running every start value in both modes exposes ordering faults at once, since linear and interleaved sequences differ from the second beat for odd starts.

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int unsigned LSB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [LSB_W-1:0] start_i,
  output logic [LSB_W-1:0] start_q,
  output logic [LSB_W-1:0] beat_q,
  output logic             beat_step,
  output logic             beat_wrap
);
  localparam logic [LSB_W-1:0] BeatLast = {LSB_W{1'b1}};

  // step only when no load competes (load has priority)
  assign beat_step = adv_i && !load_i;
  assign beat_wrap = beat_step && (beat_q == BeatLast);

  function automatic logic [LSB_W-1:0] beat_next(input logic [LSB_W-1:0] b);
    return b + LSB_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
    end else if (beat_step) begin
      beat_q  <= beat_next(beat_q);
    end
  end

  // R7: beat count wraps to zero after the last beat
  p_beat_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_wrap |=> (beat_q == '0));

  // R2: a load restarts the beat count
  p_load_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_q == '0) && (start_q == $past(start_i)));

  // R4: suspend keeps the count
  p_hold_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(beat_q) && $stable(start_q));
endmodule

// File: rtl/burst_order_unit.sv
module burst_order_unit #(
  parameter int unsigned LSB_W = 2
) (
  input  logic             mode_i,
  input  logic [LSB_W-1:0] start_q,
  input  logic [LSB_W-1:0] beat_q,
  output logic [LSB_W-1:0] linear_addr,
  output logic [LSB_W-1:0] ilv_addr,
  output logic [LSB_W-1:0] addr_o
);
  // linear: start plus beats, wrapping inside the block
  function automatic logic [LSB_W-1:0] linear_of(input logic [LSB_W-1:0] s,
                                                  input logic [LSB_W-1:0] b);
    return s + b;
  endfunction

  assign linear_addr = linear_of(start_q, beat_q);

  // interleaved: bitwise XOR of start and beat
  for (genvar g = 0; g < LSB_W; g++) begin : g_ilv_bit
    assign ilv_addr[g] = start_q[g] ^ beat_q[g];
  end

  assign addr_o = mode_i ? ilv_addr : linear_addr;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned LSB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             mode_i,
  input  logic [LSB_W-1:0] start_i,
  output logic [LSB_W-1:0] addr_o
);
  logic [LSB_W-1:0] start_q;
  logic [LSB_W-1:0] beat_q;
  logic             beat_step;
  logic             beat_wrap;
  logic [LSB_W-1:0] linear_addr;
  logic [LSB_W-1:0] ilv_addr;

  burst_beat_counter #(.LSB_W(LSB_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .adv_i     (adv_i),
    .start_i   (start_i),
    .start_q   (start_q),
    .beat_q    (beat_q),
    .beat_step (beat_step),
    .beat_wrap (beat_wrap)
  );

  burst_order_unit #(.LSB_W(LSB_W)) i_order (
    .mode_i      (mode_i),
    .start_q     (start_q),
    .beat_q      (beat_q),
    .linear_addr (linear_addr),
    .ilv_addr    (ilv_addr),
    .addr_o      (addr_o)
  );

  // R2/R3: output shows the loaded start on the next cycle
  p_load_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(start_i)));

  // R4: suspended burst holds its address while the mode stays put
  p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ((addr_o == $past(addr_o)) || (mode_i != $past(mode_i))));

  // R5: linear step is plus one modulo block size
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_step && !mode_i) |=> (!mode_i -> (addr_o == LSB_W'($past(addr_o) + 1'b1))));

  // R6: interleaved address XOR start equals the beat ordinal
  p_ilv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_step && mode_i) |=> (mode_i -> ((addr_o ^ start_q) == LSB_W'($past(addr_o ^ start_q) + 1'b1))));
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [1:0] start_i = 2'b00;
  logic [1:0] addr_o;

  int vectors = 0;
  int errors = 0;
  int m_start = 0;
  int m_beat = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .mode_i(mode_i), .start_i(start_i), .addr_o(addr_o)
  );

  // expected address from the requirement text, not the RTL
  function automatic int expect_addr(input int s, input int k, input bit m);
    int r;
    if (!m) r = (s + k) % 4;
    else begin
      r = 0;
      if (((s / 2) % 2) != ((k / 2) % 2)) r += 2;
      if ((s % 2) != (k % 2)) r += 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input int exp);
    vectors++;
    if (int'(addr_o) !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%0d expected=%0d (start=%0d beat=%0d mode=%0d)",
               req, addr_o, exp, m_start, m_beat, mode_i);
    end
  endtask

  // drive at negedge, clock once, check at next negedge
  task automatic cyc(input bit ld, input bit adv, input int s, input string req);
    load_i  = ld;
    adv_i   = adv;
    start_i = 2'(s);
    @(posedge clk);
    if (ld) begin m_start = s; m_beat = 0; end
    else if (adv) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    check(req, expect_addr(m_start, m_beat, mode_i));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0b17;
    void'($urandom(seed));
    @(negedge clk);
    check("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 0, "R1");

    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(1'b1, 1'b0, s, "R2");
        for (int k = 0; k < 4; k++)
          cyc(1'b0, 1'b1, 3 - s, m ? "R6" : "R5");
        // after four beats the walk is back at the start
        check("R7", s);
      end
      // suspend mid-burst
      cyc(1'b1, 1'b0, 1, "R2");
      cyc(1'b0, 1'b1, 0, m ? "R6" : "R5");
      cyc(1'b0, 1'b0, 2, "R4");
      cyc(1'b0, 1'b0, 3, "R4");
      // load and advance together: load wins
      cyc(1'b1, 1'b1, 3, "R3");
      cyc(1'b0, 1'b1, 0, m ? "R6" : "R5");
      // restart in the middle of a burst
      cyc(1'b1, 1'b0, 2, "R8");
      cyc(1'b0, 1'b1, 0, "R8");
    end

    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      cyc(1'b1, 1'b0, 0, "R2");
      for (int i = 0; i < 3000; i++) begin
        bit ld, av;
        ld = ($urandom % 6) == 0;
        av = ($urandom % 3) != 0;
        cyc(ld, av, int'($urandom % 4), ld ? (av ? "R3" : "R8") : (av ? (m ? "R6" : "R5") : "R4"));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule